// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block drives the six control lines of a digital step attenuator or gain stage. It accepts its setting in one of two ways, chosen by a mode pin. In serial mode a three-wire port shifts a word in, most significant bit first. A latch-enable level then moves that word to the output. In parallel mode six data lines either pass straight through while latch enable is held high, or are captured when latch enable is pulsed. In every mode the output holds while latch enable is low.

All external pins are asynchronous to the system clock. Each goes through a two-stage synchroniser, and the serial clock is edge-detected in the clock domain. After reset the output rests at full attenuation for a programmable settling time. When that time ends, an initial setting is applied. It comes from two strap pins when latch enable is low, or from the parallel lines when latch enable is high. A cascade output carries the bit pushed out of the top of the shift register, so several devices can share one serial line.

The output is active low. Bit k cleared removes 2^k half-decibel steps of gain. An all-ones word means 0 dB of reduction and all zeros means 31.5 dB.

Top module: `atten_ctrl_top`

## Requirements
- R1: With the mode pin high and latch enable low, each rising serial clock edge shifts the data pin into bit 0 of a 6-bit shift register. The first bit sent ends in bit 5.
- R2: In serial mode, a high latch enable copies the shift register to the output word.
- R3: Serial clock edges that arrive while latch enable is high leave the shift register and the cascade output unchanged.
- R4: With the mode pin low, serial clock and data have no effect on the shift register or the cascade output.
- R5: In parallel mode with latch enable held high, the output follows the parallel lines.
- R6: In any mode, the output word does not change while latch enable is low. A later latch-enable pulse in parallel mode loads the parallel lines.
- R7: The output is active low. Bit k (k = 0..5) weighs 2^k × 0.5 dB, so the word is the bitwise inverse of the reduction in half-decibel steps.
- R8: When the settling time ends with latch enable low, the strap pins {strap[1], strap[0]} set the output: 00 gives 000000 (31.5 dB), 01 gives 001111 (24 dB), 10 gives 011111 (16 dB), and 11 gives 111111 (0 dB).
- R9: Reset sets the output to 000000 and the shift register and cascade output to 0. Until PWRUP_CYCLES cycles after reset release, all inputs are ignored. When the settling time ends with latch enable high, the parallel lines set the output.
- R10: On each accepted shift, the cascade output takes the value that bit 5 of the shift register held before the shift.
- R11: A change on a synchronised input shows at the outputs on the third rising system clock edge after it. It does not show on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serMode | input | 1 | 1 selects serial mode, 0 selects parallel mode |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock, rising-edge active |
| latchEn | input | 1 | Latch enable |
| parWord | input | 6 | Parallel control lines, bit 0 is the 0.5 dB step |
| strapSel | input | 2 | Strap pins choosing the initial state |
| attnWordN | output | 6 | Registered active-low attenuation control word |
| chainOut | output | 1 | Cascade output for the next device |

## Verification
Errors in the shift register stay hidden until latch enable rises. The cascade output shows them one serial edge after the shift, and they reach the output word three system clocks after the latch enable edge. So the bench looks at the cascade line on every shift, then loads each word and compares the result. A wrong settling counter or a wrong strap decode only shows at the single point where the initial state is applied. The bench therefore reads the output both inside the settling window and after it, once for each strap combination. A synchroniser with the wrong depth moves the output update by one system clock. Only a check at the exact cycle exposes this.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;
  localparam int WORD_W  = 6;
  localparam int STRAP_W = 2;

  typedef struct packed {
    logic shift;      // move serial data into the shift register
    logic loadShift;  // shift register -> output word
    logic loadPar;    // parallel lines -> output word
    logic loadStrap;  // strap decode -> output word
  } strobe_t;

  typedef enum logic {PH_SETTLE, PH_RUN} phase_t;

  function automatic logic [WORD_W-1:0] strapWord(input logic [STRAP_W-1:0] sel);
    logic [WORD_W-1:0] w;
    unique case (sel)
      2'b00:   w = 6'b000000;
      2'b01:   w = 6'b001111;
      2'b10:   w = 6'b011111;
      default: w = 6'b111111;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/atten_ctrl_sync.sv
module atten_ctrl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/atten_ctrl_ctl.sv
module atten_ctrl_ctl
  import atten_ctrl_pkg::*;
#(
  parameter int PWRUP_CYCLES = 10_000_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeS,
  input  logic    sclkS,
  input  logic    leS,
  output strobe_t strb
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYCLES - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             sclkPrev;
  logic             sclkRise;
  logic             settleEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_SETTLE;
      cnt      <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (phase == PH_SETTLE) begin
        if (settleEnd) phase <= PH_RUN;
        else           cnt   <= cnt + 1'b1;
      end
    end
  end

  assign sclkRise  = sclkS & ~sclkPrev;
  assign settleEnd = (phase == PH_SETTLE) && (cnt == LAST);

  always_comb begin
    strb = '0;
    if (settleEnd) begin
      if (leS) strb.loadPar   = 1'b1;
      else     strb.loadStrap = 1'b1;
    end else if (phase == PH_RUN) begin
      if (modeS) begin
        if (leS)           strb.loadShift = 1'b1;
        else if (sclkRise) strb.shift     = 1'b1;
      end else if (leS) begin
        strb.loadPar = 1'b1;
      end
    end
  end

  AST_CLK_MASKED_BY_LE: assert property (@(posedge clk) disable iff (!rstN)
    leS |-> !strb.shift); // R3
  AST_PAR_MODE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !modeS |-> !strb.shift); // R4
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R2
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETTLE && !settleEnd) |-> (strb == '0)); // R9
endmodule

// File: rtl/atten_ctrl_path.sv
module atten_ctrl_path
  import atten_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               serDataS,
  input  logic [WORD_W-1:0]  parS,
  input  logic [STRAP_W-1:0] strapS,
  output logic [WORD_W-1:0]  attnWordN,
  output logic               chainOut
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      chainOut <= 1'b0;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], serDataS};
      chainOut <= shiftReg[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               attnWordN <= '0;
    else if (strb.loadShift) attnWordN <= shiftReg;
    else if (strb.loadPar)   attnWordN <= parS;
    else if (strb.loadStrap) attnWordN <= strapWord(strapS);
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadShift || strb.loadPar || strb.loadStrap) |=> $stable(attnWordN)); // R6
  AST_SHREG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> ($stable(shiftReg) && $stable(chainOut))); // R3
endmodule

// File: rtl/atten_ctrl_top.sv
module atten_ctrl_top
  import atten_ctrl_pkg::*;
#(
  parameter int PWRUP_CYCLES = 10_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serMode,
  input  logic        serData,
  input  logic        serClk,
  input  logic        latchEn,
  input  logic [5:0]  parWord,
  input  logic [1:0]  strapSel,
  output logic [5:0]  attnWordN,
  output logic        chainOut
);
  localparam int SYNC_W = WORD_W + STRAP_W + 4;

  logic [SYNC_W-1:0]  syncBus;
  logic [WORD_W-1:0]  parS;
  logic [STRAP_W-1:0] strapS;
  logic               modeS, dataS, sclkS, leS;
  strobe_t            strb;

  atten_ctrl_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({strapSel, serMode, serData, serClk, latchEn, parWord}),
    .syncOut (syncBus)
  );

  assign {strapS, modeS, dataS, sclkS, leS, parS} = syncBus;

  atten_ctrl_ctl #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .modeS (modeS),
    .sclkS (sclkS),
    .leS   (leS),
    .strb  (strb)
  );

  atten_ctrl_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .serDataS  (dataS),
    .parS      (parS),
    .strapS    (strapS),
    .attnWordN (attnWordN),
    .chainOut  (chainOut)
  );
endmodule

// File: tb/atten_ctrl_top_tb.sv
`timescale 1ns/1ps
module atten_ctrl_top_tb;
  localparam int PWRUP = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serMode = 1'b0, serData = 1'b0, serClk = 1'b0, latchEn = 1'b0;
  logic [5:0] parWord = '0;
  logic [1:0] strapSel = '0;
  logic [5:0] attnWordN;
  logic chainOut;

  int nTests = 0;
  int nFail  = 0;

  typedef struct {
    logic [5:0] word;
    logic       chain;
    bit         useChain;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [5:0] shModel = '0;
  logic       chainModel = 1'b0;
  logic [5:0] curWord = '0;

  always #10 clk = ~clk;

  atten_ctrl_top #(.PWRUP_CYCLES(PWRUP)) u_dut (
    .clk(clk), .rstN(rstN), .serMode(serMode), .serData(serData),
    .serClk(serClk), .latchEn(latchEn), .parWord(parWord),
    .strapSel(strapSel), .attnWordN(attnWordN), .chainOut(chainOut)
  );

  // scoreboard monitor
  initial begin
    exp_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      #1;
      nTests++;
      if (attnWordN !== it.word || (it.useChain && chainOut !== it.chain)) begin
        nFail++;
        $display("FAIL %s: word=%b chain=%b expected word=%b chain=%b",
                 it.tag, attnWordN, chainOut, it.word, it.chain);
      end
    end
  end

  task automatic expectOut(input logic [5:0] w, input logic c, input bit useC, input string tag);
    exp_t it;
    @(negedge clk);
    it.word = w; it.chain = c; it.useChain = useC; it.tag = tag;
    q.push_back(it);
    #2;
  endtask

  function automatic logic [5:0] dbWord(input int halfSteps);
    return ~6'(halfSteps); // R7 active-low weights
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serPulse(input logic d);
    serData = d;
    idle(3);
    serClk = 1'b1;
    if (serMode && !latchEn) begin
      chainModel = shModel[5];
      shModel = {shModel[4:0], d};
    end
    idle(5);
    serClk = 1'b0;
    idle(4);
  endtask

  task automatic shiftWord(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      serPulse(w[i]);
      expectOut(curWord, chainModel, 1'b1, "R10");
    end
  endtask

  task automatic lePulse();
    latchEn = 1'b1;
    idle(6);
    latchEn = 1'b0;
    idle(40);
  endtask

  task automatic doReset(input logic [1:0] strap, input logic le, input logic [5:0] par,
                         input logic [5:0] expWord, input string tag);
    rstN = 1'b0;
    strapSel = strap; latchEn = le; parWord = par; serMode = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(10);
    expectOut(6'b000000, 1'b0, 1'b1, "R9");
    idle(60);
    expectOut(expWord, 1'b0, 1'b1, tag);
    curWord = expWord;
    shModel = '0; chainModel = 1'b0;
  endtask

  // stimulus timing monitor (R1 serial interface limits)
  realtime lastRise = -1.0e9, lastData = -1.0e9, lastLe = -1.0e9;
  int timingViol = 0;
  always @(posedge serClk) begin
    if ($realtime - lastRise < 100.0) timingViol++;
    if ($realtime - lastData < 20.0)  timingViol++;
    lastRise = $realtime;
  end
  always @(serData) begin
    if ($realtime - lastRise < 20.0) timingViol++;
    lastData = $realtime;
  end
  always @(posedge latchEn) begin
    if ($realtime - lastLe < 630.0) timingViol++;
    lastLe = $realtime;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // power-up states (R8, R9)
    doReset(2'b00, 1'b0, 6'b101010, 6'b000000, "R8");
    doReset(2'b01, 1'b0, 6'b101010, 6'b001111, "R8");
    doReset(2'b10, 1'b0, 6'b101010, 6'b011111, "R8");
    doReset(2'b11, 1'b1, 6'b101010, 6'b101010, "R9");
    latchEn = 1'b0; idle(40);
    doReset(2'b11, 1'b0, 6'b000000, 6'b111111, "R8");

    // serial mode: shift, hold, load (R1, R2, R6, R10)
    serMode = 1'b1; idle(5);
    shiftWord(6'b110010);
    expectOut(6'b111111, chainModel, 1'b1, "R6");
    lePulse();
    curWord = 6'b110010;
    expectOut(curWord, chainModel, 1'b1, "R2");
    if (shModel !== 6'b110010) begin nTests++; nFail++; $display("FAIL R1: model=%b expected=110010", shModel); end

    // clock masked while LE high (R3)
    latchEn = 1'b1; idle(4);
    serPulse(1'b0); serPulse(1'b0); serPulse(1'b1);
    latchEn = 1'b0; idle(40);
    expectOut(curWord, chainModel, 1'b1, "R3");
    lePulse();
    expectOut(6'b110010, chainModel, 1'b1, "R3");

    // second word pushes first out of the cascade (R10, R1)
    shiftWord(6'b001101);
    lePulse();
    curWord = 6'b001101;
    expectOut(curWord, chainModel, 1'b1, "R1");

    // parallel mode: latched load and serial inputs ignored (R6, R4)
    serMode = 1'b0; idle(5);
    parWord = 6'b111000; idle(10);
    expectOut(curWord, chainModel, 1'b1, "R6");
    lePulse();
    curWord = 6'b111000;
    expectOut(curWord, chainModel, 1'b1, "R6");
    serPulse(1'b1); serPulse(1'b1); serPulse(1'b0);
    expectOut(curWord, chainModel, 1'b1, "R4");
    serMode = 1'b1; idle(5);
    lePulse();
    curWord = 6'b001101;
    expectOut(curWord, chainModel, 1'b1, "R4");

    // direct parallel (R5, R7)
    serMode = 1'b0; idle(5);
    latchEn = 1'b1;
    parWord = dbWord(1);  idle(6); expectOut(6'b111110, chainModel, 1'b1, "R7");
    parWord = dbWord(32); idle(6); expectOut(6'b011111, chainModel, 1'b1, "R7");
    parWord = dbWord(63); idle(6); expectOut(6'b000000, chainModel, 1'b1, "R5");
    parWord = dbWord(25); idle(6); expectOut(6'b100110, chainModel, 1'b1, "R5");

    // exact latency (R11)
    @(negedge clk);
    parWord = 6'b010110;
    @(negedge clk);
    expectOut(6'b100110, chainModel, 1'b1, "R11");
    expectOut(6'b010110, chainModel, 1'b1, "R11");

    // latched parallel hold then update (R6)
    latchEn = 1'b0; idle(40);
    parWord = 6'b010101; idle(10);
    expectOut(6'b010110, chainModel, 1'b1, "R6");
    lePulse();
    expectOut(6'b010101, chainModel, 1'b1, "R6");

    idle(5);
    nTests++;
    if (timingViol != 0) begin
      nFail++;
      $display("FAIL R1: serial timing violations=%0d expected=0", timingViol);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule